// File: doc/BRIEF.md
# Quad Digital Potentiometer Serial Control Slave

This block is the two-wire serial front end of a four-channel, 256-step digital potentiometer controller. It oversamples the bus clock and data lines with the system clock, recognises START and STOP conditions, and responds to a 7-bit device address. The upper five address bits are fixed by a parameter. The lowest two come from strap pins, so four of these blocks can share one bus. After a write address, the first byte is an instruction. It picks one of four wiper channels, can reload that wiper to midscale, sets a shutdown request bit and loads two latched general-purpose logic outputs. Each further byte in the same transfer rewrites the chosen wiper. After a read address, the chosen wiper value is returned on every byte the master clocks, until the master answers with a not-acknowledge.

The block drives the bus only through an open-drain pull-down enable (`sda_pull`). The four 8-bit wiper codes, the combined shutdown flag and the two logic outputs are plain level outputs. The shutdown flag combines an active-low external shutdown pin with the stored shutdown bit. When that pin is wired to the first logic output, the part is held in shutdown after reset and leaves it once a transfer sets that output. Internally, the link sequencer hands decoded instruction and data bytes to the wiper bank as single-cycle valid strobes. The bank always accepts them, so there is no back-pressure path. The bus has no clock stretching.

Top module: `qdp_i2c_slave`

## Requirements
- R1: After reset every wiper code is 0x80, both logic outputs are 0, the stored shutdown bit is 0 and `sda_pull` is 0.
- R2: The slave acknowledges an address byte by asserting `sda_pull` for the ninth clock only when its upper seven bits equal {01011, strap_a1, strap_a0}. Any other address is not acknowledged, and the rest of that transfer changes no output.
- R3: The instruction byte is decoded MSB first as: bits 7:6 channel, bit 5 midscale reload, bit 4 shutdown request, bit 3 logic output 1, bit 2 logic output 2, bits 1:0 unused. A transfer of only address, instruction and STOP updates the logic outputs and the shutdown bit and leaves all wipers unchanged.
- R4: Each data byte after an acknowledged instruction writes the selected wiper and is acknowledged. This repeats for any number of bytes until STOP or START.
- R5: An instruction with the midscale bit set loads 0x80 into the selected wiper.
- R6: After a read address, each byte clocked out carries the wiper selected by the last instruction, MSB first. A master not-acknowledge ends the read, and `sda_pull` stays 0 from then on until the next START.
- R7: `shutdown` is 1 when `shdn_n` is 0 or the stored shutdown bit is 1. With `shdn_n` wired to `logic_o1`, the block is in shutdown after reset and leaves it when an instruction sets logic output 1.
- R8: START is a falling data line while the clock is high, and STOP is a rising data line while the clock is high. A repeated START begins a new address phase. STOP releases the bus, and a transfer cut short before its instruction byte is complete changes nothing.
- R9: `sda_pull` only rises while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_a1 | input | 1 | Address bit 1 strap |
| strap_a0 | input | 1 | Address bit 0 strap |
| shdn_n | input | 1 | Active-low external shutdown request |
| wiper_codes | output | 32 | Four wiper codes, channel n in bits 8n+7:8n |
| shutdown | output | 1 | Combined shutdown flag |
| logic_o1 | output | 1 | Latched general-purpose logic output 1 |
| logic_o2 | output | 1 | Latched general-purpose logic output 2 |
| sda_pull | output | 1 | Open-drain pull-down enable for the data line |

## Verification
The main function is exercised with a write carrying two data bytes, which shows that later bytes overwrite earlier ones. An instruction-only transfer shows that logic outputs change while wipers do not. A foreign address is sent to confirm that the slave stays silent and changes nothing. A three-byte read ending in a not-acknowledge shows that the same value repeats and that the bus is released. Further patterns cover a midscale reload, shutdown driven from the stored bit, from the external pin and from the loop back to logic output 1, a repeated START that switches channel mid-transfer, and a transfer aborted by STOP partway through the instruction byte, which separates early commit from commit after a complete byte.

// File: rtl/qdp_pkg.sv
package qdp_pkg;

  typedef enum logic [3:0] {
    LS_IDLE,
    LS_ADDR,
    LS_ADDR_ACK,
    LS_INSTR,
    LS_INSTR_ACK,
    LS_WDATA,
    LS_WDATA_ACK,
    LS_RDATA,
    LS_RACK,
    LS_IGNORE
  } link_state_e;

  typedef struct packed {
    logic [1:0] chan;
    logic       mid;
    logic       sd;
    logic       o1;
    logic       o2;
  } instr_t;

  // Upper six bits of the instruction byte; bits 1:0 carry nothing.
  function automatic instr_t decode_instr(input logic [5:0] hi);
    instr_t r;
    r.chan = hi[5:4];
    r.mid  = hi[3];
    r.sd   = hi[2];
    r.o1   = hi[1];
    r.o2   = hi[0];
    return r;
  endfunction

endpackage

// File: rtl/qdp_line_sync.sv
module qdp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_d, sda_d, scl_lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_in;
          sda_sh <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_in};
          sda_sh <= {sda_sh[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_sh[TOP];
      sda_d <= sda_sh[TOP];
    end
  end

  assign scl_lvl   = scl_sh[TOP];
  assign sda_lvl   = sda_sh[TOP];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/qdp_link_fsm.sv
module qdp_link_fsm
  import qdp_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          HI_W    = 5,
  parameter logic [HI_W-1:0] ADDR_HI = 5'b01011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [1:0]    strap,
  input  logic [DW-1:0] rd_word,
  output logic          instr_valid,
  output logic [DW-1:0] instr_byte,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data,
  output logic          sda_pull,
  output link_state_e   state
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  logic [DW-1:0] shreg, tx;
  logic [CW-1:0] bitcnt;
  logic          rnw, mack;
  logic          byte_done;

  assign byte_done = scl_fall && (bitcnt == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= LS_IDLE;
      shreg       <= '0;
      tx          <= '0;
      bitcnt      <= '0;
      rnw         <= 1'b0;
      mack        <= 1'b0;
      sda_pull    <= 1'b0;
      instr_valid <= 1'b0;
      instr_byte  <= '0;
      wr_valid    <= 1'b0;
      wr_data     <= '0;
    end else begin
      instr_valid <= 1'b0;
      wr_valid    <= 1'b0;
      if (start_evt) begin
        state    <= LS_ADDR;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (stop_evt) begin
        state    <= LS_IDLE;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          LS_ADDR, LS_INSTR, LS_WDATA: begin
            if (scl_rise) begin
              shreg  <= {shreg[DW-2:0], sda_lvl};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (state == LS_ADDR) begin
                if (shreg[DW-1:1] == {ADDR_HI, strap}) begin
                  sda_pull <= 1'b1;
                  rnw      <= shreg[0];
                  state    <= LS_ADDR_ACK;
                end else begin
                  state <= LS_IGNORE;
                end
              end else if (state == LS_INSTR) begin
                sda_pull    <= 1'b1;
                instr_valid <= 1'b1;
                instr_byte  <= shreg;
                state       <= LS_INSTR_ACK;
              end else begin
                sda_pull <= 1'b1;
                wr_valid <= 1'b1;
                wr_data  <= shreg;
                state    <= LS_WDATA_ACK;
              end
            end
          end
          LS_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rnw) begin
                tx       <= rd_word;
                sda_pull <= ~rd_word[DW-1];
                state    <= LS_RDATA;
              end else begin
                sda_pull <= 1'b0;
                state    <= LS_INSTR;
              end
            end
          end
          LS_INSTR_ACK, LS_WDATA_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= LS_WDATA;
            end
          end
          LS_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              bitcnt   <= '0;
              sda_pull <= 1'b0;
              state    <= LS_RACK;
            end else if (scl_fall) begin
              sda_pull <= ~tx[DW-2];
              tx       <= {tx[DW-2:0], 1'b0};
            end
          end
          LS_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                tx       <= rd_word;
                sda_pull <= ~rd_word[DW-1];
                state    <= LS_RDATA;
              end else begin
                state <= LS_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/qdp_wiper_bank.sv
module qdp_wiper_bank
  import qdp_pkg::*;
#(
  parameter int          NCH = 4,
  parameter int          DW  = 8,
  parameter logic [DW-1:0] MID = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [DW-1:0]     instr_byte,
  input  logic              wr_valid,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH*DW-1:0] wipers,
  output logic [DW-1:0]     rd_word,
  output logic              sd_q,
  output logic              o1_q,
  output logic              o2_q
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  instr_t         ins;
  logic [CHW-1:0] sel;

  assign ins = decode_instr(instr_byte[DW-1:DW-6]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel  <= '0;
      sd_q <= 1'b0;
      o1_q <= 1'b0;
      o2_q <= 1'b0;
    end else if (instr_valid) begin
      sel  <= CHW'(ins.chan);
      sd_q <= ins.sd;
      o1_q <= ins.o1;
      o2_q <= ins.o2;
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wipers[g*DW +: DW] <= MID;
        end else if (instr_valid && ins.mid && (CHW'(ins.chan) == CHW'(g))) begin
          wipers[g*DW +: DW] <= MID;
        end else if (wr_valid && (sel == CHW'(g))) begin
          wipers[g*DW +: DW] <= wr_data;
        end
      end
    end
  endgenerate

  assign rd_word = wipers[sel*DW +: DW];

endmodule

// File: rtl/qdp_i2c_slave.sv
module qdp_i2c_slave #(
  parameter int           STAGES  = 2,
  parameter logic [4:0]   ADDR_HI = 5'b01011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic        strap_a1,
  input  logic        strap_a0,
  input  logic        shdn_n,
  output logic [31:0] wiper_codes,
  output logic        shutdown,
  output logic        logic_o1,
  output logic        logic_o2,
  output logic        sda_pull
);
  localparam int NCH = 4;
  localparam int DW  = 8;

  logic          sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic          instr_valid, wr_valid, sd_q;
  logic [DW-1:0] instr_byte, wr_data, rd_word;
  qdp_pkg::link_state_e link_state;

  qdp_line_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  qdp_link_fsm #(.DW(DW), .HI_W(5), .ADDR_HI(ADDR_HI)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .strap({strap_a1, strap_a0}), .rd_word(rd_word),
    .instr_valid(instr_valid), .instr_byte(instr_byte),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .sda_pull(sda_pull), .state(link_state)
  );

  qdp_wiper_bank #(.NCH(NCH), .DW(DW), .MID(8'h80)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_byte(instr_byte),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .wipers(wiper_codes), .rd_word(rd_word),
    .sd_q(sd_q), .o1_q(logic_o1), .o2_q(logic_o2)
  );

  assign shutdown = ~shdn_n | sd_q;

endmodule

// File: rtl/qdp_checker.sv
module qdp_checker
  import qdp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        scl_in,
  input logic        sda_pull,
  input logic        stop_evt,
  input logic        instr_valid,
  input logic        wr_valid,
  input logic        sd_q,
  input logic [31:0] wipers,
  input link_state_e state
);

  // R9: the pull-down only engages while the bus clock is low
  p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_in);

  // R8: a STOP always leaves the data line released
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  // R3: the shutdown bit moves only on a decoded instruction
  p_sd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(sd_q));

  // R4: wipers move only on a data byte or an instruction
  p_wiper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && !wr_valid) |=> $stable(wipers));

  // R2: an unaddressed or finished transfer never drives the bus
  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_IGNORE) |-> !sda_pull);

  // R4: instruction and data strobes never coincide
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_valid && wr_valid));

endmodule

bind qdp_i2c_slave qdp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
  .stop_evt(stop_evt), .instr_valid(instr_valid), .wr_valid(wr_valid),
  .sd_q(sd_q), .wipers(wiper_codes), .state(u_link.state)
);

// File: tb/sim_qdp_i2c_slave.sv
module sim_qdp_i2c_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic tie_o1 = 1'b1;
  logic shdn_direct = 1'b1;
  logic [31:0] wiper_codes;
  logic shutdown, logic_o1, logic_o2, sda_pull;
  logic sda_line, shdn_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int    exp_q[$];
  int    act_q[$];
  string tag_q[$];
  event  got_item;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;
  assign shdn_n   = tie_o1 ? logic_o1 : shdn_direct;

  qdp_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .strap_a1(1'b1), .strap_a0(1'b0), .shdn_n(shdn_n),
    .wiper_codes(wiper_codes), .shutdown(shutdown),
    .logic_o1(logic_o1), .logic_o2(logic_o2), .sda_pull(sda_pull)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pairs each observed item with its expectation
  initial begin
    forever begin
      @(got_item);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        chk(tag_q.pop_front(), 32'(act_q.pop_front()), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic q_wait;
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; q_wait; scl = 1'b1; q_wait;
    sda_m = 1'b0; q_wait; scl = 1'b0; q_wait;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; q_wait; scl = 1'b1; q_wait; sda_m = 1'b1; q_wait;
  endtask

  task automatic wbit(input logic b);
    sda_m = b; q_wait; scl = 1'b1; q_wait; q_wait; scl = 1'b0; q_wait;
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; q_wait; scl = 1'b1; q_wait; b = sda_line; q_wait;
    scl = 1'b0; q_wait;
  endtask

  // Driver: sends a byte, expects an acknowledge value on the ninth clock
  task automatic wbyte(input logic [7:0] v, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(a);
    exp_q.push_back(int'(exp_ack));
    tag_q.push_back(tag);
    act_q.push_back(int'(a));
    -> got_item;
  endtask

  // Driver: reads a byte, expects a value, then sends ACK or NACK
  task automatic rbyte(input logic [7:0] exp_v, input logic nack, input string tag);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    exp_q.push_back(int'(exp_v));
    tag_q.push_back(tag);
    act_q.push_back(int'(v));
    -> got_item;
    wbit(nack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state; R7 power-up shutdown with shdn_n looped to logic_o1
    chk("R1 wipers", wiper_codes, 32'h80808080);
    chk("R1 o1/o2/pull", {29'd0, logic_o1, logic_o2, sda_pull}, 32'd0);
    chk("R7 powerup shutdown", {31'd0, shutdown}, 32'd1);

    // R4 repeated write to channel 2, O1 set by instruction
    bus_start;
    wbyte(8'h5C, 1'b0, "R2 addr ack");
    wbyte(8'h88, 1'b0, "R3 instr ack");
    wbyte(8'h3C, 1'b0, "R4 data ack 1");
    wbyte(8'h5A, 1'b0, "R4 data ack 2");
    bus_stop;
    q_wait;
    chk("R4 repeated write", wiper_codes, 32'h805A8080);
    chk("R7 exit shutdown via o1", {30'd0, logic_o1, shutdown}, 32'h2);

    // R3 instruction-only transfer: outputs change, wipers do not
    bus_start;
    wbyte(8'h5C, 1'b0, "R2 addr ack");
    wbyte(8'h0C, 1'b0, "R3 instr ack");
    bus_stop;
    q_wait;
    chk("R3 instr-only wipers", wiper_codes, 32'h805A8080);
    chk("R3 o1/o2", {30'd0, logic_o1, logic_o2}, 32'h3);

    // R2 foreign address: no acknowledge, nothing changes
    bus_start;
    wbyte(8'h5E, 1'b1, "R2 foreign addr nack");
    wbyte(8'h88, 1'b1, "R2 ignored byte nack");
    wbyte(8'h11, 1'b1, "R2 ignored data nack");
    bus_stop;
    q_wait;
    chk("R2 foreign wipers", wiper_codes, 32'h805A8080);
    chk("R2 foreign o2 kept", {31'd0, logic_o2}, 32'h1);

    // R6 repeated read of channel 2
    bus_start;
    wbyte(8'h5C, 1'b0, "R2 addr ack");
    wbyte(8'h88, 1'b0, "R3 instr ack");
    bus_stop;
    bus_start;
    wbyte(8'h5D, 1'b0, "R6 read addr ack");
    rbyte(8'h5A, 1'b0, "R6 read byte 1");
    rbyte(8'h5A, 1'b0, "R6 read byte 2");
    rbyte(8'h5A, 1'b1, "R6 read byte 3");
    q_wait;
    chk("R6 released after nack", {31'd0, sda_pull}, 32'd0);
    bus_stop;
    q_wait;
    chk("R6 read leaves wipers", wiper_codes, 32'h805A8080);

    // R5 midscale reload of channel 2
    bus_start;
    wbyte(8'h5C, 1'b0, "R2 addr ack");
    wbyte(8'hA8, 1'b0, "R5 instr ack");
    bus_stop;
    q_wait;
    chk("R5 midscale", wiper_codes, 32'h80808080);

    // R7 stored shutdown bit and external pin
    bus_start;
    wbyte(8'h5C, 1'b0, "R2 addr ack");
    wbyte(8'h18, 1'b0, "R7 instr ack");
    bus_stop;
    q_wait;
    chk("R7 sd bit shutdown", {31'd0, shutdown}, 32'd1);
    bus_start;
    wbyte(8'h5C, 1'b0, "R2 addr ack");
    wbyte(8'h08, 1'b0, "R7 instr ack");
    bus_stop;
    q_wait;
    chk("R7 sd cleared", {31'd0, shutdown}, 32'd0);
    tie_o1 = 1'b0;
    shdn_direct = 1'b0;
    q_wait;
    chk("R7 pin shutdown", {31'd0, shutdown}, 32'd1);
    shdn_direct = 1'b1;
    q_wait;
    chk("R7 pin released", {31'd0, shutdown}, 32'd0);

    // R8 repeated START switches channel mid-transfer
    bus_start;
    wbyte(8'h5C, 1'b0, "R2 addr ack");
    wbyte(8'h48, 1'b0, "R8 instr ack");
    wbyte(8'h11, 1'b0, "R8 data ack");
    bus_start;
    wbyte(8'h5C, 1'b0, "R8 restart addr ack");
    wbyte(8'hC8, 1'b0, "R8 instr ack 2");
    wbyte(8'h99, 1'b0, "R8 data ack 2");
    bus_stop;
    q_wait;
    chk("R8 repeated start", wiper_codes, 32'h99801180);

    // R8 STOP partway through the instruction byte commits nothing
    bus_start;
    wbyte(8'h5C, 1'b0, "R2 addr ack");
    wbit(1'b1); wbit(1'b1); wbit(1'b1);
    bus_stop;
    q_wait;
    chk("R8 aborted wipers", wiper_codes, 32'h99801180);
    chk("R8 aborted outputs", {30'd0, logic_o1, logic_o2}, 32'h2);
    chk("R8 aborted pull", {31'd0, sda_pull}, 32'd0);

    q_wait;
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule